// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits between a byte-level I2C receiver and the rest of a slave controller. The receiver reports START, repeated START and STOP events and hands over each assembled byte. The recognizer looks at the first byte, or the first two bytes, after every START and decides whether this device is being addressed. For each address byte it requests an ACK or a NACK. When addressing completes it raises a one-cycle interrupt and enters slave mode, reporting the transfer direction. It does not drive the pins and does not take part in the data phase that follows.

Software configures the block through a small register port. A primary register holds a 7-bit own address and a general-call enable. A second register holds the low byte of a 10-bit own address. Programming the top five bits of the primary register to 11110b switches the block to 10-bit addressing, and bits [2:1] of that register then act as the two upper address bits. A status register holds a sticky copy of the interrupt, and any write to it clears it.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: After reset the primary, extended and status registers read 00h, `slave_active` is 0 and `addr10` is 000h.
- R2: `cfg_sel` 0 selects the primary register, 1 the extended register and 2 the status register (sticky flag in bit 0). Writes to 0 and 1 read back unchanged, and `addr10` always equals {primary[2:1], extended[7:0]}.
- R3: In 7-bit mode (primary[7:3] not 11110b), the first byte after a START whose bits [7:1] equal primary[7:1] and are not all zero gives `ack_valid`=1 and `ack_ok`=1. It also gives `addr_irq`=1 and `slave_active`=1, with `slave_rw` equal to bit 0 of the byte. All are visible in the cycle after the byte strobe.
- R4: A first byte with bits [7:1] all zero is acknowledged, interrupts and enters slave mode only when primary[0]=1. With primary[0]=0 it is NACKed, even when primary[7:1] is zero.
- R5: In 10-bit mode, a first byte whose bits [7:1] equal {11110b, primary[2:1]} is ACKed with no interrupt, and `slave_active` stays 0.
- R6: In 10-bit mode, the byte after an accepted header is compared in full with the extended register. A match ACKs, interrupts and enters slave mode, with `slave_rw` taken from bit 0 of the header byte. A mismatch NACKs.
- R7: A non-matching address byte gives `ack_valid`=1 with `ack_ok`=0, with no interrupt and no slave mode. Bytes after it are ignored until the next START.
- R8: A STOP or a START abandons a partly received 10-bit sequence and clears `slave_active` on the next edge. A STOP has priority over a START, and a START has priority over a byte.
- R9: `addr_irq` lasts exactly one cycle. Status bit 0 is set on the same edge, and any write to the status register clears it.
- R10: Bytes that arrive before the first START, after a STOP, or after addressing has completed produce no `ack_valid` and leave `slave_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 2 | Register select: 0 primary, 1 extended, 2 status |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| bus_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| bus_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte, first bus bit in bit 7 |
| ack_valid | output | 1 | An ACK/NACK decision is presented this cycle |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK, meaningful with `ack_valid` |
| addr_irq | output | 1 | One-cycle addressing interrupt |
| slave_active | output | 1 | Device is addressed as a slave |
| slave_rw | output | 1 | Direction bit of the accepted address |
| addr10 | output | 10 | Programmed 10-bit address {primary[2:1], extended} |

## Verification
Each byte strobe, START and STOP is sampled on one rising edge. The ACK decision, the interrupt, slave mode and the sticky status bit all change on that same edge, so every result is due exactly one cycle after its stimulus. Register reads and `addr10` are combinational and are due in the cycle the select is driven. The bench drives every stimulus for one cycle from a falling edge and samples at the next falling edge, which is the one cycle where the pulsed `ack_valid` and `addr_irq` are high. It then samples once more to confirm that the pulse has ended.

// File: rtl/i2c_sam_pkg.sv
// Package: shared constants and types of the I2C slave address recognizer.
// Assumes byte-wide registers; the 10-bit header prefix is fixed by the bus.
package i2c_sam_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          SEL_W      = 2;
    localparam logic [4:0]  TEN_PREFIX = 5'b11110;

    localparam logic [SEL_W-1:0] SEL_PRIM = 2'd0;
    localparam logic [SEL_W-1:0] SEL_EXT  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

    // Address phase after a START
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // no address expected
        PH_FIRST  = 2'd1,   // first address byte expected
        PH_SECOND = 2'd2,   // low byte of a 10-bit address expected
        PH_HOLD   = 2'd3    // addressing done, bytes belong to data phase
    } phase_t;

    // Decision for one received address byte
    typedef struct packed {
        logic ack;        // request ACK
        logic hit;        // addressing complete
        logic ten_first;  // valid 10-bit header, wait for low byte
    } verdict_t;

endpackage

// File: rtl/sam_regs.sv
// Module: software-visible registers of the address recognizer.
// Holds the primary and extended address registers and the sticky
// interrupt flag. Assumes one write per cycle; set of the flag wins over a
// clearing write in the same cycle.
module sam_regs
    import i2c_sam_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          flag_set,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  prim_q,
    output logic [W-1:0]  ext_q,
    output logic          flag_q
);

    // Register writes, flag set and flag clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= '0;
            ext_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr && sel == SEL_PRIM) prim_q <= wdata;
            if (wr && sel == SEL_EXT)  ext_q  <= wdata;
            if (flag_set)
                flag_q <= 1'b1;
            else if (wr && sel == SEL_STAT)
                flag_q <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (sel)
            SEL_PRIM: rdata = prim_q;
            SEL_EXT:  rdata = ext_q;
            SEL_STAT: rdata = {{(W-1){1'b0}}, flag_q};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/sam_match.sv
// Module: combinational address comparator.
// Produces the ACK / hit / header verdict for the byte just received, given
// the current address phase. Assumes bit 7 of the byte is the first bit on
// the bus and bit 0 is the direction bit of a header or 7-bit address.
module sam_match
    import i2c_sam_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] prim,
    input  logic [W-1:0] ext,
    input  logic [W-1:0] rx_byte,
    input  phase_t       phase,
    output verdict_t     verdict,
    output logic         ten_mode
);

    localparam int AW = W - 1;

    logic [AW-1:0] rx_addr;
    logic [AW-1:0] hdr_addr;
    logic          gc_hit;
    logic          own7_hit;
    logic          hdr_hit;
    logic          low_hit;

    // Individual comparisons on the received byte
    always_comb begin
        rx_addr  = rx_byte[W-1:1];
        ten_mode = (prim[W-1:W-5] == TEN_PREFIX);
        hdr_addr = {TEN_PREFIX, prim[2:1]};
        gc_hit   = prim[0] && (rx_addr == '0);
        own7_hit = !ten_mode && (rx_addr != '0) && (rx_addr == prim[W-1:1]);
        hdr_hit  = ten_mode && (rx_addr == hdr_addr);
        low_hit  = (rx_byte == ext);
    end

    // Verdict for the current phase
    always_comb begin
        verdict = '0;
        unique case (phase)
            PH_FIRST: begin
                verdict.hit       = gc_hit || own7_hit;
                verdict.ten_first = !gc_hit && hdr_hit;
                verdict.ack       = gc_hit || own7_hit || hdr_hit;
            end
            PH_SECOND: begin
                verdict.hit = low_hit;
                verdict.ack = low_hit;
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/sam_ctrl.sv
// Module: address phase sequencer.
// Tracks the phase after START/STOP, registers the ACK decision, the
// interrupt pulse, slave mode and the direction bit. Assumes event pulses
// last one cycle; priority is STOP, then START, then a received byte.
module sam_ctrl
    import i2c_sam_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_start,
    input  logic         bus_stop,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  verdict_t     verdict,
    output phase_t       phase,
    output logic         hit_now,
    output logic         ack_valid,
    output logic         ack_ok,
    output logic         addr_irq,
    output logic         slave_active,
    output logic         slave_rw
);

    logic byte_take;
    logic hdr_rw_q;

    // A byte counts only when no bus event overrides it and an address is due
    always_comb begin
        byte_take = rx_valid && !bus_stop && !bus_start &&
                    (phase == PH_FIRST || phase == PH_SECOND);
        hit_now   = byte_take && verdict.hit;
    end

    // Phase sequencing and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            ack_valid    <= 1'b0;
            ack_ok       <= 1'b0;
            addr_irq     <= 1'b0;
            slave_active <= 1'b0;
            slave_rw     <= 1'b0;
            hdr_rw_q     <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            addr_irq  <= hit_now;
            if (bus_stop) begin
                phase        <= PH_IDLE;
                slave_active <= 1'b0;
            end else if (bus_start) begin
                phase        <= PH_FIRST;
                slave_active <= 1'b0;
            end else if (byte_take) begin
                ack_valid <= 1'b1;
                ack_ok    <= verdict.ack;
                if (verdict.hit) begin
                    phase        <= PH_HOLD;
                    slave_active <= 1'b1;
                    slave_rw     <= (phase == PH_SECOND) ? hdr_rw_q : rx_data[0];
                end else if (verdict.ten_first) begin
                    phase    <= PH_SECOND;
                    hdr_rw_q <= rx_data[0];
                end else begin
                    phase <= PH_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_slave_addr_match.sv
// Module: I2C slave address recognizer (top).
// Decides after each START whether this device is addressed (7-bit,
// general call or 10-bit) and reports ACK requests, an interrupt pulse and
// slave mode. Assumes a byte-level receiver supplies START/STOP pulses and
// assembled bytes; pins, stretching and the data phase are handled elsewhere.
module i2c_slave_addr_match
    import i2c_sam_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cfg_sel,
    input  logic          cfg_wr,
    input  logic [W-1:0]  cfg_wdata,
    output logic [W-1:0]  cfg_rdata,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_data,
    output logic          ack_valid,
    output logic          ack_ok,
    output logic          addr_irq,
    output logic          slave_active,
    output logic          slave_rw,
    output logic [W+1:0]  addr10
);

    logic [W-1:0] prim_q;
    logic [W-1:0] ext_q;
    logic         status_flag;
    logic         hit_now;
    logic         ten_mode;
    phase_t       phase;
    verdict_t     verdict;

    sam_regs #(.W(W), .SW(SW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (cfg_sel),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .flag_set (hit_now),
        .rdata    (cfg_rdata),
        .prim_q   (prim_q),
        .ext_q    (ext_q),
        .flag_q   (status_flag)
    );

    sam_match #(.W(W)) u_match (
        .prim     (prim_q),
        .ext      (ext_q),
        .rx_byte  (rx_data),
        .phase    (phase),
        .verdict  (verdict),
        .ten_mode (ten_mode)
    );

    sam_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .verdict      (verdict),
        .phase        (phase),
        .hit_now      (hit_now),
        .ack_valid    (ack_valid),
        .ack_ok       (ack_ok),
        .addr_irq     (addr_irq),
        .slave_active (slave_active),
        .slave_rw     (slave_rw)
    );

    // Programmed 10-bit address for read-back
    always_comb addr10 = {prim_q[2:1], ext_q};

endmodule

// File: rtl/sam_checker.sv
// Module: property checker for the address recognizer, bound to the top.
// Assumes the one-cycle event timing stated in the requirements.
module sam_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_stop,
    input logic rx_valid,
    input logic ack_valid,
    input logic ack_ok,
    input logic addr_irq,
    input logic slave_active,
    input logic status_flag
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |=> !addr_irq); // R9

    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> status_flag); // R9

    AST_IRQ_IS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> (ack_valid && ack_ok)); // R3

    AST_IRQ_ENTERS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> slave_active); // R6

    AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_ok) |-> (!addr_irq && !slave_active)); // R7

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !slave_active); // R8

    AST_ACK_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> $past(rx_valid)); // R10

endmodule

bind i2c_slave_addr_match sam_checker u_sam_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_stop     (bus_stop),
    .rx_valid     (rx_valid),
    .ack_valid    (ack_valid),
    .ack_ok       (ack_ok),
    .addr_irq     (addr_irq),
    .slave_active (slave_active),
    .status_flag  (status_flag)
);

// File: tb/i2c_slave_addr_match_test.sv
// Bench: vector table of address scenarios, then directed corner tests.
module i2c_slave_addr_match_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // {prim, ext, two, b1, b2, ack1, irq1, av2, ack2, irq2, slave, rw}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'hA4, 8'h00, 1'b0, 8'hA4, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hA4, 8'h00, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'hA4, 8'h00, 1'b1, 8'hA6, 8'hA4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hA5, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hA4, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hF4, 8'h3C, 1'b1, 8'hF4, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hF4, 8'h3C, 1'b1, 8'hF5, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'hF4, 8'h3C, 1'b1, 8'hF4, 8'h3D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hF4, 8'h3C, 1'b1, 8'hF2, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hF4, 8'h3C, 1'b0, 8'hA4, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hF5, 8'h3C, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hF0, 8'h00, 1'b1, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hFE, 8'h00, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       ack_valid, ack_ok, addr_irq, slave_active, slave_rw;
    logic [9:0] addr10;

    int tests = 0;
    int fails = 0;
    logic [7:0] rd_val;

    i2c_slave_addr_match uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_sel (cfg_sel), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_start (bus_start), .bus_stop (bus_stop),
        .rx_valid (rx_valid), .rx_data (rx_data),
        .ack_valid (ack_valid), .ack_ok (ack_ok), .addr_irq (addr_irq),
        .slave_active (slave_active), .slave_rw (slave_rw), .addr10 (addr10)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic do_start();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic do_stop();
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, rd_val); chk("R1 primary reset", rd_val, 8'h00);
        rd(2'd1, rd_val); chk("R1 extended reset", rd_val, 8'h00);
        rd(2'd2, rd_val); chk("R1 status reset", rd_val, 8'h00);
        chk("R1 slave_active reset", slave_active, 1'b0);
        chk("R1 addr10 reset", addr10, 10'h000);

        // R2: register access and 10-bit read-back
        wr(2'd0, 8'hF6);
        wr(2'd1, 8'h5A);
        rd(2'd0, rd_val); chk("R2 primary readback", rd_val, 8'hF6);
        rd(2'd1, rd_val); chk("R2 extended readback", rd_val, 8'h5A);
        chk("R2 addr10", addr10, 10'h35A);

        // R10: byte before any START is ignored
        wr(2'd0, 8'hA4);
        send(8'hA4);
        chk("R10 byte before START ack_valid", ack_valid, 1'b0);
        chk("R10 byte before START slave", slave_active, 1'b0);

        // Vector table: R3..R7
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] v;
            v = VEC[i];
            wr(2'd0, v[39:32]);
            wr(2'd1, v[31:24]);
            wr(2'd2, 8'h00);
            do_start();
            send(v[22:15]);
            chk($sformatf("R3/R4/R5/R7 vec%0d first ack_valid", i), ack_valid, 1'b1);
            chk($sformatf("R3/R4/R5/R7 vec%0d first ack_ok", i), ack_ok, v[6]);
            chk($sformatf("R3/R5 vec%0d first irq", i), addr_irq, v[5]);
            chk($sformatf("R5 vec%0d slave after first", i), slave_active, v[5]);
            if (v[23]) begin
                send(v[14:7]);
                chk($sformatf("R6/R7 vec%0d second ack_valid", i), ack_valid, v[4]);
                if (v[4])
                    chk($sformatf("R6 vec%0d second ack_ok", i), ack_ok, v[3]);
                chk($sformatf("R6 vec%0d second irq", i), addr_irq, v[2]);
            end
            chk($sformatf("R3/R6 vec%0d slave_active", i), slave_active, v[1]);
            if (v[1])
                chk($sformatf("R3/R6 vec%0d slave_rw", i), slave_rw, v[0]);
            do_stop();
        end

        // R9: single-cycle interrupt, sticky flag, clear on write
        wr(2'd0, 8'h6C);
        wr(2'd2, 8'h00);
        do_start();
        send(8'h6C);
        chk("R9 irq high", addr_irq, 1'b1);
        rd(2'd2, rd_val); chk("R9 sticky set", rd_val, 8'h01);
        @(negedge clk);
        chk("R9 irq dropped", addr_irq, 1'b0);
        rd(2'd2, rd_val); chk("R9 sticky held", rd_val, 8'h01);

        // R10: byte after addressing is ignored
        send(8'h12);
        chk("R10 data byte ack_valid", ack_valid, 1'b0);
        chk("R10 data byte slave kept", slave_active, 1'b1);
        wr(2'd2, 8'h00);
        rd(2'd2, rd_val); chk("R9 sticky cleared", rd_val, 8'h00);

        // R8: STOP clears slave mode
        do_stop();
        chk("R8 STOP clears slave", slave_active, 1'b0);

        // R8: STOP abandons a partial 10-bit sequence
        wr(2'd0, 8'hF4);
        wr(2'd1, 8'h3C);
        do_start();
        send(8'hF4);
        chk("R8 header acked", ack_ok, 1'b1);
        do_stop();
        send(8'h3C);
        chk("R8 low byte after STOP ignored", ack_valid, 1'b0);
        chk("R8 no slave after STOP", slave_active, 1'b0);

        // R8: repeated START restarts at the first byte
        do_start();
        send(8'hF4);
        do_start();
        send(8'h3C);
        chk("R8 byte after restart is first byte", ack_valid, 1'b1);
        chk("R8 byte after restart NACK", ack_ok, 1'b0);
        chk("R8 no irq after restart", addr_irq, 1'b0);

        // R8: STOP beats a simultaneous START
        do_stop();
        bus_stop = 1'b1; bus_start = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0; bus_start = 1'b0;
        send(8'hF4);
        chk("R8 STOP priority over START", ack_valid, 1'b0);

        // R8: START beats a simultaneous byte
        wr(2'd0, 8'hA4);
        do_start();
        bus_start = 1'b1; rx_valid = 1'b1; rx_data = 8'h22;
        @(negedge clk);
        bus_start = 1'b0; rx_valid = 1'b0;
        chk("R8 byte with START dropped", ack_valid, 1'b0);
        send(8'hA4);
        chk("R8 next byte addressed", slave_active, 1'b1);
        do_stop();

        finish_run();
    end

endmodule